// File: doc/BRIEF.md
# Trap and Exception Return Controller

This block keeps a processor's exception state and steers the program counter when a software trap or an external interrupt is taken, and when the handler returns. It owns three pieces of live state. The status register acts as an interrupt mask. The cause register collects interrupt events. A set of saved registers holds the interrupted PC, the status, the masked cause and an exception data word. Pipeline flushing and moves between these registers and the register file are handled elsewhere.

A trap or interrupt saves the current PC, the status and the masked cause. It clears the status, and it restarts the cause register from the events that arrive in that same cycle. It then redirects fetch to the service routine start address. A software trap also stores its sign-extended immediate as exception data. An interrupt stores zero there. A return restores the status from its saved copy and redirects fetch to the saved PC. Every action produces a registered one-cycle redirect strobe with its target address.

Top module: `trap_seq_unit`

## Requirements
- R1: After reset the status register equals the parameter SR_RESET (default 0x000000FF). The cause register, all saved registers and the redirect target are zero, and the redirect strobe is low.
- R2: A trap strobe causes, on the next clock, the saved PC to hold the PC presented with the strobe, and the redirect target to hold the service routine address presented with it.
- R3: When a trap or interrupt is taken, the saved status receives the old status register and the status register becomes zero.
- R4: When a trap or interrupt is taken, the saved cause receives the old cause register ANDed with the old status mask. The cause register then holds exactly the events present in that cycle.
- R5: On a software trap, the exception data register receives the 16-bit immediate sign-extended to 32 bits: bit 15 is copied into bits 31:16.
- R6: A return strobe, when nothing of higher priority is taken, restores the status register from the saved status and sets the redirect target to the saved PC.
- R7: When no trap or interrupt is taken, each asserted event line sets its cause bit, and the bit stays set.
- R8: When the cause register ANDed with the status mask is nonzero at a clock edge and no trap strobe is present, an interrupt is taken. It uses the same save sequence and redirect as a trap, but the exception data is zero.
- R9: The redirect strobe is high for exactly the one cycle after each taken trap, interrupt or return, and low otherwise.
- R10: When several actions are possible at one edge, the priority is software trap, then interrupt, then return. The losing actions have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_req_i | input | 1 | Software trap strobe |
| rfe_req_i | input | 1 | Return-from-exception strobe |
| cur_pc_i | input | 32 | PC of the instruction in this cycle |
| trap_imm_i | input | 16 | Trap immediate, before sign extension |
| evt_i | input | 32 | Interrupt event lines |
| isr_base_i | input | 32 | Service routine start address |
| redir_valid_o | output | 1 | Next-PC override strobe |
| redir_pc_o | output | 32 | Next-PC override target |
| status_o | output | 32 | Current status (interrupt mask) |
| cause_o | output | 32 | Current cause register |
| saved_pc_o | output | 32 | Saved PC |
| saved_status_o | output | 32 | Saved status |
| saved_cause_o | output | 32 | Saved masked cause |
| exc_data_o | output | 32 | Exception data |

## Verification
Three pairs of actions can fall on one edge.

- A software trap can meet a pending interrupt. The bench provokes this by latching an unmasked event one cycle before a trap strobe. The saved cause must then show the masked event and the exception data must be the immediate.
- A pending interrupt can meet a return strobe. The interrupt must win: the status stays cleared and the redirect goes to the service routine, not to the saved PC.
- A trap and a return can be strobed together. The trap must win.

Random stimulus then mixes all three, and every clock is judged against a behavioural model.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
   // action chosen at a clock edge, in priority order trap > irq > return
   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_TRAP = 2'd1,
      ACT_IRQ  = 2'd2,
      ACT_RFE  = 2'd3
   } act_e;
endpackage

// File: rtl/trap_cause_track.sv
module trap_cause_track #(
   parameter int NUM_EVT = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_i,
   input  logic [NUM_EVT-1:0] evt_i,
   output logic [NUM_EVT-1:0] cause_o
);
   for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     bit_q <= 1'b0;
         else if (clr_i) bit_q <= evt_i[i];
         else            bit_q <= bit_q | evt_i[i];
      end
      assign cause_o[i] = bit_q;
   end

   AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> ((cause_o & $past(cause_o)) == $past(cause_o))); // R7
   AST_CAUSE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cause_o == $past(evt_i))); // R4
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
   import trap_seq_pkg::*;
#(
   parameter int NUM_EVT = 32,
   parameter bit IRQ_EN  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trap_req_i,
   input  logic               rfe_req_i,
   input  logic [NUM_EVT-1:0] cause_i,
   input  logic [NUM_EVT-1:0] mask_i,
   output act_e               act_o
);
   logic irq_pend;

   if (IRQ_EN) begin : g_irq
      assign irq_pend = |(cause_i & mask_i);
   end else begin : g_no_irq
      assign irq_pend = 1'b0;
   end

   always_comb begin
      if (trap_req_i)    act_o = ACT_TRAP;
      else if (irq_pend) act_o = ACT_IRQ;
      else if (rfe_req_i) act_o = ACT_RFE;
      else               act_o = ACT_NONE;
   end

   AST_RFE_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      (rfe_req_i && (|(cause_i & mask_i)) && IRQ_EN) |-> (act_o != ACT_RFE)); // R10
endmodule

// File: rtl/trap_state_regs.sv
module trap_state_regs
   import trap_seq_pkg::*;
#(
   parameter int          XLEN     = 32,
   parameter int          NUM_EVT  = 32,
   parameter int          IMM_W    = 16,
   parameter logic [31:0] SR_RESET = 32'h0000_00FF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  act_e               act_i,
   input  logic [XLEN-1:0]    cur_pc_i,
   input  logic [IMM_W-1:0]   imm_i,
   input  logic [NUM_EVT-1:0] cause_i,
   output logic [XLEN-1:0]    sr_o,
   output logic [XLEN-1:0]    epc_o,
   output logic [XLEN-1:0]    esr_o,
   output logic [NUM_EVT-1:0] eca_o,
   output logic [XLEN-1:0]    edata_o
);
   localparam int EXT_W = XLEN - IMM_W;

   logic [XLEN-1:0] imm_ext;
   logic            take;

   if (EXT_W > 0) begin : g_ext
      assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
   end else begin : g_noext
      assign imm_ext = imm_i[XLEN-1:0];
   end

   assign take = (act_i == ACT_TRAP) || (act_i == ACT_IRQ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_o    <= SR_RESET[XLEN-1:0];
         epc_o   <= '0;
         esr_o   <= '0;
         eca_o   <= '0;
         edata_o <= '0;
      end else if (take) begin
         epc_o   <= cur_pc_i;
         esr_o   <= sr_o;
         eca_o   <= cause_i & sr_o[NUM_EVT-1:0];
         sr_o    <= '0;
         edata_o <= (act_i == ACT_TRAP) ? imm_ext : '0;
      end else if (act_i == ACT_RFE) begin
         sr_o    <= esr_o;
      end
   end

   AST_TAKE_CLEARS_SR: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (sr_o == '0)); // R3
   AST_TAKE_SAVES_PC: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (epc_o == $past(cur_pc_i))); // R2
   AST_ECA_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> ((eca_o & ~$past(sr_o[NUM_EVT-1:0])) == '0)); // R4
   AST_IRQ_EDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i == ACT_IRQ) |=> (edata_o == '0)); // R8
   AST_RFE_RESTORES_SR: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i == ACT_RFE) |=> (sr_o == $past(esr_o))); // R6
endmodule

// File: rtl/trap_redirect.sv
module trap_redirect
   import trap_seq_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  act_e            act_i,
   input  logic [XLEN-1:0] isr_base_i,
   input  logic [XLEN-1:0] epc_i,
   output logic            valid_o,
   output logic [XLEN-1:0] pc_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         pc_o    <= '0;
      end else begin
         valid_o <= (act_i != ACT_NONE);
         if (act_i == ACT_RFE)       pc_o <= epc_i;
         else if (act_i != ACT_NONE) pc_o <= isr_base_i;
      end
   end

   AST_STROBE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i == ACT_NONE) |=> !valid_o); // R9
   AST_RFE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i == ACT_RFE) |=> (valid_o && pc_o == $past(epc_i))); // R6
endmodule

// File: rtl/trap_seq_unit.sv
module trap_seq_unit
   import trap_seq_pkg::*;
#(
   parameter int          XLEN     = 32,
   parameter int          NUM_EVT  = 32,
   parameter int          IMM_W    = 16,
   parameter bit          IRQ_EN   = 1'b1,
   parameter logic [31:0] SR_RESET = 32'h0000_00FF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trap_req_i,
   input  logic               rfe_req_i,
   input  logic [XLEN-1:0]    cur_pc_i,
   input  logic [IMM_W-1:0]   trap_imm_i,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic [XLEN-1:0]    isr_base_i,
   output logic               redir_valid_o,
   output logic [XLEN-1:0]    redir_pc_o,
   output logic [XLEN-1:0]    status_o,
   output logic [NUM_EVT-1:0] cause_o,
   output logic [XLEN-1:0]    saved_pc_o,
   output logic [XLEN-1:0]    saved_status_o,
   output logic [NUM_EVT-1:0] saved_cause_o,
   output logic [XLEN-1:0]    exc_data_o
);
   if (NUM_EVT < 1 || NUM_EVT > XLEN) begin : g_bad_evt
      $error("NUM_EVT must lie in 1..XLEN");
   end
   if (IMM_W < 1 || IMM_W > XLEN) begin : g_bad_imm
      $error("IMM_W must lie in 1..XLEN");
   end
   if (XLEN > 32) begin : g_bad_xlen
      $error("SR_RESET is 32 bits wide; XLEN may not exceed it");
   end

   act_e act;
   logic restart_cause;

   assign restart_cause = (act == ACT_TRAP) || (act == ACT_IRQ);

   trap_arbiter #(.NUM_EVT(NUM_EVT), .IRQ_EN(IRQ_EN)) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .trap_req_i (trap_req_i),
      .rfe_req_i  (rfe_req_i),
      .cause_i    (cause_o),
      .mask_i     (status_o[NUM_EVT-1:0]),
      .act_o      (act)
   );

   trap_cause_track #(.NUM_EVT(NUM_EVT)) u_cause (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (restart_cause),
      .evt_i   (evt_i),
      .cause_o (cause_o)
   );

   trap_state_regs #(.XLEN(XLEN), .NUM_EVT(NUM_EVT), .IMM_W(IMM_W),
                     .SR_RESET(SR_RESET)) u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_i    (act),
      .cur_pc_i (cur_pc_i),
      .imm_i    (trap_imm_i),
      .cause_i  (cause_o),
      .sr_o     (status_o),
      .epc_o    (saved_pc_o),
      .esr_o    (saved_status_o),
      .eca_o    (saved_cause_o),
      .edata_o  (exc_data_o)
   );

   trap_redirect #(.XLEN(XLEN)) u_redir (
      .clk        (clk),
      .rst_n      (rst_n),
      .act_i      (act),
      .isr_base_i (isr_base_i),
      .epc_i      (saved_pc_o),
      .valid_o    (redir_valid_o),
      .pc_o       (redir_pc_o)
   );

   AST_TRAP_REDIRECTS: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req_i |=> (redir_valid_o && redir_pc_o == $past(isr_base_i)
                      && status_o == '0)); // R10
endmodule

// File: tb/trap_seq_unit_bench.sv
`timescale 1ns/1ps
module trap_seq_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trap_req = 1'b0, rfe_req = 1'b0;
   logic [31:0] cur_pc = '0, evt = '0, isr = '0;
   logic [15:0] imm = '0;
   logic        rv;
   logic [31:0] rpc, st, ca, spc, sst, sca, edat;

   trap_seq_unit u_trap_seq_unit (
      .clk(clk), .rst_n(rst_n), .trap_req_i(trap_req), .rfe_req_i(rfe_req),
      .cur_pc_i(cur_pc), .trap_imm_i(imm), .evt_i(evt), .isr_base_i(isr),
      .redir_valid_o(rv), .redir_pc_o(rpc), .status_o(st), .cause_o(ca),
      .saved_pc_o(spc), .saved_status_o(sst), .saved_cause_o(sca),
      .exc_data_o(edat));

   always #2.5 clk = ~clk;

   int checks = 0, fails = 0, cyc = 0;
   bit done = 0;

   // behavioural reference state
   logic        m_rv;
   logic [31:0] m_rpc, m_sr, m_ca, m_spc, m_sst, m_sca, m_ed;

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_rv = 0; m_rpc = 0; m_sr = 32'h0000_00FF; m_ca = 0;
      m_spc = 0; m_sst = 0; m_sca = 0; m_ed = 0;
   endtask

   task automatic model_step();
      bit irq = (m_ca & m_sr) != 0;
      logic [31:0] o_sr = m_sr, o_ca = m_ca;
      if (trap_req || irq) begin
         m_spc = cur_pc; m_sst = o_sr; m_sca = o_ca & o_sr; m_sr = 0;
         m_ed  = trap_req ? {{16{imm[15]}}, imm} : 32'h0;
         m_ca  = evt; m_rv = 1; m_rpc = isr;
      end else if (rfe_req) begin
         m_sr = m_sst; m_rpc = m_spc; m_rv = 1; m_ca = o_ca | evt;
      end else begin
         m_rv = 0; m_ca = o_ca | evt;
      end
   endtask

   task automatic cmp_all();
      chk("R9", "redir_valid", {31'b0, rv}, {31'b0, m_rv});
      chk("R6", "redir_pc", rpc, m_rpc);
      chk("R3", "status", st, m_sr);
      chk("R7", "cause", ca, m_ca);
      chk("R2", "saved_pc", spc, m_spc);
      chk("R3", "saved_status", sst, m_sst);
      chk("R4", "saved_cause", sca, m_sca);
      chk("R5", "exc_data", edat, m_ed);
   endtask

   // drive at a falling edge, advance the model, compare at the next falling edge
   task automatic apply(bit t, bit r, logic [31:0] pc, logic [15:0] im,
                        logic [31:0] ev, logic [31:0] base);
      trap_req = t; rfe_req = r; cur_pc = pc; imm = im; evt = ev; isr = base;
      model_step();
      @(negedge clk);
      cmp_all();
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; trap_req = 0; rfe_req = 0; evt = 0;
      model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1; checks++; fails++;
         $display("FAIL R9 watchdog: got %0d cycles expected under 20000", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   localparam logic [31:0] ISR = 32'h8000_0040;

   initial begin
      do_reset();
      // R1 reset state
      chk("R1", "status", st, 32'h0000_00FF);
      chk("R1", "redir_valid", {31'b0, rv}, 32'h0);
      chk("R1", "cause", ca, 32'h0);
      chk("R1", "saved_pc", spc, 32'h0);
      chk("R1", "exc_data", edat, 32'h0);

      // random mix of traps, interrupts, returns and events
      for (int i = 0; i < 400; i++) begin
         bit t = ($urandom % 7) == 0;
         bit r = ($urandom % 5) == 0;
         logic [31:0] e = (($urandom % 6) == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
         apply(t, r, $urandom, 16'($urandom), e, $urandom);
      end

      do_reset();
      apply(0, 0, 32'h0, 16'h0, 32'h0000_0300, ISR);
      chk("R7", "cause after unmasked-out events", ca, 32'h0000_0300);
      apply(0, 0, 32'h0, 16'h0, 32'h0, ISR);
      chk("R7", "cause held", ca, 32'h0000_0300);
      chk("R9", "idle strobe", {31'b0, rv}, 32'h0);
      apply(0, 0, 32'h0, 16'h0, 32'h0000_0004, ISR);
      // trap meets pending interrupt: trap wins
      apply(1, 0, 32'h0000_1000, 16'h8001, 32'h0000_0400, ISR);
      chk("R2", "redir target", rpc, ISR);
      chk("R2", "saved_pc", spc, 32'h0000_1000);
      chk("R3", "status cleared", st, 32'h0);
      chk("R3", "saved_status", sst, 32'h0000_00FF);
      chk("R4", "saved_cause", sca, 32'h0000_0004);
      chk("R4", "cause restart", ca, 32'h0000_0400);
      chk("R5", "sext immediate", edat, 32'hFFFF_8001);
      chk("R10", "trap over irq data", edat, 32'hFFFF_8001);
      apply(0, 0, 32'h0, 16'h0, 32'h0, ISR);
      chk("R9", "single pulse", {31'b0, rv}, 32'h0);
      apply(0, 1, 32'h0, 16'h0, 32'h0, ISR);
      chk("R6", "return target", rpc, 32'h0000_1000);
      chk("R6", "status restored", st, 32'h0000_00FF);
      apply(0, 0, 32'h0000_2000, 16'h0, 32'h0000_0010, ISR);
      // pending interrupt meets return: interrupt wins
      apply(0, 1, 32'h0000_2004, 16'h7777, 32'h0, ISR);
      chk("R8", "irq redirect", rpc, ISR);
      chk("R8", "irq exc_data", edat, 32'h0);
      chk("R8", "irq saved_pc", spc, 32'h0000_2004);
      chk("R8", "irq saved_cause", sca, 32'h0000_0010);
      chk("R10", "irq over return status", st, 32'h0);
      // trap and return together: trap wins
      apply(1, 1, 32'h0000_3000, 16'h1234, 32'h0, ISR);
      chk("R10", "trap over return target", rpc, ISR);
      chk("R5", "positive immediate", edat, 32'h0000_1234);
      chk("R10", "saved_pc", spc, 32'h0000_3000);
      apply(0, 1, 32'h0, 16'h0, 32'h0, ISR);
      chk("R6", "return to trap pc", rpc, 32'h0000_3000);
      apply(0, 0, 32'h0, 16'h0, 32'h0, ISR);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule